// File: doc/BRIEF.md
# Cascaded Mappable Interrupt Controller

This block gathers level-sensitive interrupt requests into two local groups of eight sources each and raises one CPU interrupt line per group. A third group of eight mappable sources does not drive a CPU line directly. It is qualified by two independent map masks, and each masked result folds into one reserved bit of a local group. Map mask 0 feeds bit 7 of local group 0, and map mask 1 feeds bit 3 of local group 1. One shared map status can therefore reach either CPU line, or both, under software control.

Software reaches the block through a byte-wide register port. Writes take effect at the clock edge and reads are combinational. Through this port it can read the live status of each group, set and read back four mask registers, and write-one-to-clear two timer pending flags. A one-cycle terminal-count pulse from an external timer sets each flag.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: All four masks are 0 after reset. Each reads back the last byte written at its own offset: local0 mask 0x01, local1 mask 0x03, map mask 0 0x08, map mask 1 0x0C.
- R2: Local0 status (0x00) and local1 status (0x02) return the live source levels. A write to either offset changes no register.
- R3: Local0 status bit 7 is the OR of (map sources AND map mask 0). The raw local0 source input at bit 7 is ignored.
- R4: Local1 status bit 3 is the OR of (map sources AND map mask 1). The raw local1 source input at bit 3 is ignored.
- R5: Map status (0x04) returns the live map source levels, unmasked.
- R6: `irq0_o` is 1 in the cycle after (local0 status AND local0 mask) is nonzero, and 0 otherwise. `irq1_o` follows the same rule for local1.
- R7: A one-cycle pulse on `tmr_tc_i[n]` sets pending flag n. The flag holds until cleared. It appears on `tmr_pend_o[n]` and in bit n of a read at 0x10.
- R8: Writing to 0x10 clears pending flag n when data bit n is 1 and leaves it unchanged when data bit n is 0. Writing 0x03 clears both flags.
- R9: When a set pulse and a clear write for the same flag fall in one cycle, the flag ends up set.
- R10: A read at any unmapped offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| loc0_src_i | input | 8 | Local group 0 source levels |
| loc1_src_i | input | 8 | Local group 1 source levels |
| map_src_i | input | 8 | Mappable source levels |
| tmr_tc_i | input | 2 | Timer terminal-count pulses |
| irq0_o | output | 1 | CPU interrupt from local group 0 |
| irq1_o | output | 1 | CPU interrupt from local group 1 |
| tmr_pend_o | output | 2 | Timer pending flags |

## Verification
The bench uses the default parameters: 8-bit groups, cascade bits at 7 and 3, two timer flags and a 5-bit offset space. With these values the register map has a gap between map status and map mask 0, so unmapped reads can be probed. The same shared map byte can be steered into one group, both groups or neither. With two timer flags, a partial clear (bit 0 only) and a full clear (0x03) can be told apart. The vector table covers pairs of mask settings where a source passes one mask stage but is stopped by the other. The directed part covers a set pulse and a clear landing in the same cycle.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int unsigned NUM_MSK = 4;
  localparam int unsigned MSK_L0 = 0;
  localparam int unsigned MSK_L1 = 1;
  localparam int unsigned MSK_M0 = 2;
  localparam int unsigned MSK_M1 = 3;

  localparam int unsigned OFF_L0_STAT  = 0;
  localparam int unsigned OFF_L0_MSK   = 1;
  localparam int unsigned OFF_L1_STAT  = 2;
  localparam int unsigned OFF_L1_MSK   = 3;
  localparam int unsigned OFF_MAP_STAT = 4;
  localparam int unsigned OFF_MAP_MSK0 = 8;
  localparam int unsigned OFF_MAP_MSK1 = OFF_MAP_MSK0 + 4;
  localparam int unsigned OFF_TMR_CLR  = 16;

  function automatic int unsigned msk_off(int unsigned idx);
    case (idx)
      MSK_L0:  return OFF_L0_MSK;
      MSK_L1:  return OFF_L1_MSK;
      MSK_M0:  return OFF_MAP_MSK0;
      default: return OFF_MAP_MSK1;
    endcase
  endfunction
endpackage

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_cascade_pkg::*;
#(
  parameter int unsigned GRP_W  = 8,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [GRP_W-1:0]                wdata_i,
  output logic [NUM_MSK-1:0][GRP_W-1:0]   msk_o
);
  for (genvar g = 0; g < NUM_MSK; g++) begin : g_msk
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(msk_off(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     msk_o[g] <= '0;
      else if (we_i && addr_i == OFF)  msk_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/irq_local_grp.sv
module irq_local_grp #(
  parameter int unsigned GRP_W    = 8,
  parameter int unsigned CASC_BIT = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GRP_W-1:0] src_i,
  input  logic             casc_i,
  input  logic [GRP_W-1:0] msk_i,
  output logic [GRP_W-1:0] stat_o,
  output logic             irq_o
);
  // cascade replaces the raw source at its reserved position
  always_comb begin
    stat_o           = src_i;
    stat_o[CASC_BIT] = casc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(stat_o & msk_i);
  end
endmodule

// File: rtl/irq_pend_flags.sv
module irq_pend_flags #(
  parameter int unsigned NUM_TMR = 2,
  parameter int unsigned GRP_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_TMR-1:0] tc_i,
  input  logic               clr_we_i,
  input  logic [GRP_W-1:0]   wdata_i,
  output logic [NUM_TMR-1:0] pend_o
);
  for (genvar g = 0; g < NUM_TMR; g++) begin : g_pend
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       pend_o[g] <= 1'b0;
      else if (tc_i[g])                  pend_o[g] <= 1'b1;
      else if (clr_we_i && wdata_i[g])   pend_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter int unsigned GRP_W     = 8,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned CASC0_BIT = 7,
  parameter int unsigned CASC1_BIT = 3,
  parameter int unsigned NUM_TMR   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [GRP_W-1:0]   wdata_i,
  output logic [GRP_W-1:0]   rdata_o,
  input  logic [GRP_W-1:0]   loc0_src_i,
  input  logic [GRP_W-1:0]   loc1_src_i,
  input  logic [GRP_W-1:0]   map_src_i,
  input  logic [NUM_TMR-1:0] tmr_tc_i,
  output logic               irq0_o,
  output logic               irq1_o,
  output logic [NUM_TMR-1:0] tmr_pend_o
);
  localparam logic [ADDR_W-1:0] A_L0S = ADDR_W'(OFF_L0_STAT);
  localparam logic [ADDR_W-1:0] A_L0M = ADDR_W'(OFF_L0_MSK);
  localparam logic [ADDR_W-1:0] A_L1S = ADDR_W'(OFF_L1_STAT);
  localparam logic [ADDR_W-1:0] A_L1M = ADDR_W'(OFF_L1_MSK);
  localparam logic [ADDR_W-1:0] A_MPS = ADDR_W'(OFF_MAP_STAT);
  localparam logic [ADDR_W-1:0] A_MM0 = ADDR_W'(OFF_MAP_MSK0);
  localparam logic [ADDR_W-1:0] A_MM1 = ADDR_W'(OFF_MAP_MSK1);
  localparam logic [ADDR_W-1:0] A_TCL = ADDR_W'(OFF_TMR_CLR);

  logic [NUM_MSK-1:0][GRP_W-1:0] msk_q;
  logic [GRP_W-1:0]              stat0, stat1;
  logic                          casc0, casc1;

  irq_mask_regs #(.GRP_W(GRP_W), .ADDR_W(ADDR_W)) u_msk (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .msk_o(msk_q)
  );

  assign casc0 = |(map_src_i & msk_q[MSK_M0]);
  assign casc1 = |(map_src_i & msk_q[MSK_M1]);

  irq_local_grp #(.GRP_W(GRP_W), .CASC_BIT(CASC0_BIT)) u_grp0 (
    .clk_i, .rst_ni, .src_i(loc0_src_i), .casc_i(casc0),
    .msk_i(msk_q[MSK_L0]), .stat_o(stat0), .irq_o(irq0_o)
  );

  irq_local_grp #(.GRP_W(GRP_W), .CASC_BIT(CASC1_BIT)) u_grp1 (
    .clk_i, .rst_ni, .src_i(loc1_src_i), .casc_i(casc1),
    .msk_i(msk_q[MSK_L1]), .stat_o(stat1), .irq_o(irq1_o)
  );

  irq_pend_flags #(.NUM_TMR(NUM_TMR), .GRP_W(GRP_W)) u_pend (
    .clk_i, .rst_ni, .tc_i(tmr_tc_i),
    .clr_we_i(we_i && addr_i == A_TCL), .wdata_i, .pend_o(tmr_pend_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_L0S: rdata_o = stat0;
      A_L0M: rdata_o = msk_q[MSK_L0];
      A_L1S: rdata_o = stat1;
      A_L1M: rdata_o = msk_q[MSK_L1];
      A_MPS: rdata_o = map_src_i;
      A_MM0: rdata_o = msk_q[MSK_M0];
      A_MM1: rdata_o = msk_q[MSK_M1];
      A_TCL: rdata_o[NUM_TMR-1:0] = tmr_pend_o;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
  import irq_cascade_pkg::*;
#(
  parameter int unsigned GRP_W     = 8,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned CASC0_BIT = 7,
  parameter int unsigned CASC1_BIT = 3,
  parameter int unsigned NUM_TMR   = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          we_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [GRP_W-1:0]              wdata_i,
  input logic [GRP_W-1:0]              map_src_i,
  input logic [NUM_TMR-1:0]            tmr_tc_i,
  input logic                          irq0_o,
  input logic                          irq1_o,
  input logic [NUM_TMR-1:0]            tmr_pend_o,
  input logic [NUM_MSK-1:0][GRP_W-1:0] msk_q
);
  logic clr_wr;
  assign clr_wr = we_i && addr_i == ADDR_W'(OFF_TMR_CLR);

  // R1
  msk_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFF_MAP_MSK1)) |=> msk_q[MSK_M1] == $past(wdata_i));

  // R2
  stat_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFF_L0_STAT)) |=> $stable(msk_q));

  // R3
  casc0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(map_src_i & msk_q[MSK_M0]) && msk_q[MSK_L0][CASC0_BIT]) |=> irq0_o);

  // R4
  casc1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(map_src_i & msk_q[MSK_M1]) && msk_q[MSK_L1][CASC1_BIT]) |=> irq1_o);

  // R6
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_q[MSK_L0] == '0 && msk_q[MSK_L1] == '0) |=> (!irq0_o && !irq1_o));

  // R7
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_tc_i[0] |=> tmr_pend_o[0]);

  // R7
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_pend_o[0] && !(clr_wr && wdata_i[0])) |=> tmr_pend_o[0]);

  // R8
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && wdata_i[0] && !tmr_tc_i[0]) |=> !tmr_pend_o[0]);

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_tc_i[1] && clr_wr && wdata_i[1]) |=> tmr_pend_o[1]);
endmodule

bind irq_cascade_ctrl irq_cascade_chk #(
  .GRP_W(GRP_W), .ADDR_W(ADDR_W), .CASC0_BIT(CASC0_BIT),
  .CASC1_BIT(CASC1_BIT), .NUM_TMR(NUM_TMR)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .map_src_i(map_src_i), .tmr_tc_i(tmr_tc_i),
  .irq0_o(irq0_o), .irq1_o(irq1_o), .tmr_pend_o(tmr_pend_o), .msk_q(msk_q)
);

// File: tb/irq_cascade_ctrl_tb.sv
module irq_cascade_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] l0 = '0, l1 = '0, mp = '0;
  logic [1:0] tc = '0;
  logic       irq0, irq1;
  logic [1:0] pend;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_cascade_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .loc0_src_i(l0), .loc1_src_i(l1), .map_src_i(mp),
    .tmr_tc_i(tc), .irq0_o(irq0), .irq1_o(irq1), .tmr_pend_o(pend)
  );

  typedef struct packed {
    logic [7:0] l0, l1, mp, m0, m1, mm0, mm1;
    logic e0, e1;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0},
    '{8'h01, 8'h00, 8'h00, 8'h02, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
    '{8'h00, 8'h10, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 1'b0, 1'b1},
    '{8'h00, 8'h00, 8'h04, 8'h80, 8'h00, 8'h04, 8'h00, 1'b1, 1'b0},
    '{8'h00, 8'h00, 8'h04, 8'h00, 8'h00, 8'h04, 8'h00, 1'b0, 1'b0},
    '{8'h00, 8'h00, 8'h20, 8'h00, 8'h08, 8'h00, 8'h20, 1'b0, 1'b1},
    '{8'h00, 8'h00, 8'h20, 8'h00, 8'h08, 8'h20, 8'h00, 1'b0, 1'b0},
    '{8'h80, 8'h08, 8'h00, 8'h80, 8'h08, 8'h00, 8'h00, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [7:0] st0(vec_t v);
    return {|(v.mp & v.mm0), v.l0[6:0]};
  endfunction

  function automatic logic [7:0] st1(vec_t v);
    return {v.l1[7:4], |(v.mp & v.mm1), v.l1[2:0]};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(5'h01, d); chk("R1 l0 mask reset", d, 8'h00);
    rd(5'h03, d); chk("R1 l1 mask reset", d, 8'h00);
    rd(5'h08, d); chk("R1 map mask0 reset", d, 8'h00);
    rd(5'h0C, d); chk("R1 map mask1 reset", d, 8'h00);
    chk("R6 irq reset", {6'b0, irq1, irq0}, 8'h00);
    chk("R7 pend reset", {6'b0, pend}, 8'h00);

    // vector table: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      l0 = VECS[i].l0; l1 = VECS[i].l1; mp = VECS[i].mp;
      wr(5'h01, VECS[i].m0);
      wr(5'h03, VECS[i].m1);
      wr(5'h08, VECS[i].mm0);
      wr(5'h0C, VECS[i].mm1);
      @(negedge clk);
      chk("R6 irq0", {7'b0, irq0}, {7'b0, VECS[i].e0});
      chk("R6 irq1", {7'b0, irq1}, {7'b0, VECS[i].e1});
      rd(5'h00, d); chk("R3 stat0", d, st0(VECS[i]));
      rd(5'h02, d); chk("R4 stat1", d, st1(VECS[i]));
      rd(5'h04, d); chk("R5 map stat", d, VECS[i].mp);
    end

    // R1 readback and separate offsets
    wr(5'h08, 8'h5A);
    wr(5'h0C, 8'hC3);
    rd(5'h08, d); chk("R1 map mask0 readback", d, 8'h5A);
    rd(5'h0C, d); chk("R1 map mask1 readback", d, 8'hC3);
    wr(5'h01, 8'h3C);
    rd(5'h01, d); chk("R1 l0 mask readback", d, 8'h3C);

    // R2 status writes ignored, status stays live
    l0 = 8'h21;
    wr(5'h00, 8'hFF);
    wr(5'h02, 8'hFF);
    rd(5'h01, d); chk("R2 mask after stat write", d, 8'h3C);
    rd(5'h03, d); chk("R2 l1 mask after stat write", d, 8'h08);
    rd(5'h00, d); chk("R2 stat0 live", d, 8'h21);
    l0 = 8'h02;
    rd(5'h00, d); chk("R2 stat0 follows", d, 8'h02);

    // R10 unmapped
    rd(5'h05, d); chk("R10 unmapped 0x05", d, 8'h00);
    rd(5'h1F, d); chk("R10 unmapped 0x1F", d, 8'h00);

    // R7 set and hold
    @(negedge clk); tc = 2'b01;
    @(negedge clk); tc = 2'b00;
    #1 chk("R7 pend0 set", {6'b0, pend}, 8'h01);
    repeat (3) @(negedge clk);
    rd(5'h10, d); chk("R7 pend hold read", d, 8'h01);

    // R8 zero write no effect, partial clear, full clear
    wr(5'h10, 8'h00);
    #1 chk("R8 zero write", {6'b0, pend}, 8'h01);
    @(negedge clk); tc = 2'b10;
    @(negedge clk); tc = 2'b00;
    #1 chk("R7 both set", {6'b0, pend}, 8'h03);
    wr(5'h10, 8'h01);
    #1 chk("R8 clear bit0", {6'b0, pend}, 8'h02);
    @(negedge clk); tc = 2'b01;
    @(negedge clk); tc = 2'b00;
    wr(5'h10, 8'h03);
    #1 chk("R8 clear both", {6'b0, pend}, 8'h00);

    // R9 set wins
    @(negedge clk);
    tc = 2'b10; we = 1'b1; addr = 5'h10; wdata = 8'h03;
    @(negedge clk);
    tc = 2'b00; we = 1'b0;
    #1 chk("R9 set wins", {6'b0, pend}, 8'h02);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule